// File: doc/BRIEF.md
# Two-Transaction Read/Write-Set Conflict Detector

This block follows two hardware transactions, slot 0 and slot 1. For each one it records which cache-line granules the transaction has read and which it has written. It resolves every request in the same cycle the request arrives. Each slot can issue three kinds of request: start a transaction, perform a load or store on a granule index, or finish the transaction. The detector answers each request with exactly one of three responses: grant, stall (the requester retries later) or abort.

A single mode input chooses when conflicts are detected:

- **Eager mode.** Each load and store is checked on arrival against the other transaction's sets. Age, set by the order in which the transactions started, decides the outcome. A younger requester waits. An older requester proceeds and evicts the younger transaction.
- **Lazy mode.** Loads and stores are recorded without any check. When a transaction finishes, its write-set is compared with both sets of the other transaction, and the other transaction is aborted on any overlap.

Keeping old and new data values is handled elsewhere. This block only decides who may proceed.

Top module: `rwsc_detector`

## Requirements
- R1: After reset neither slot is active and all outputs are low. A finish or access request from an inactive slot gets no grant, no stall and no abort.
- R2: A start request is always granted in its cycle. It makes the slot active and empties both of its sets. If the other slot is active at that time, the other slot becomes the older one. If both slots start in the same cycle, slot 0 is older.
- R3: A load conflicts with the other live transaction's write-set. A store conflicts with the other live transaction's read-set or write-set. A load of a granule that the other transaction has only read never conflicts. The granule index is `IDX_W` bits wide.
- R4: In eager mode, an access with no conflict is granted in its cycle. Its granule is added to the read-set for a load or to the write-set for a store.
- R5: In eager mode, a conflicting access from the younger slot is stalled and not recorded.
- R6: In eager mode, a conflicting access from the older slot is granted and recorded, and the younger slot is aborted in the same cycle.
- R7: In eager mode, when both slots access in the same cycle, the younger slot's access is stalled. The older slot's access is resolved by R4 and R6.
- R8: In lazy mode, accesses are granted and recorded without any check.
- R9: In lazy mode, a finish request is granted. The other live slot is aborted in the same cycle if the finisher's write-set shares any granule with the other slot's read-set or write-set.
- R10: When both slots request finish in the same cycle, the older slot is granted. The younger slot is aborted if R9 applies to it, otherwise it is stalled, and it may be granted on the next cycle.
- R11: In eager mode, a finish request is granted without any check.
- R12: While the other slot's finish is granted, an access request is stalled, unless R9 aborts that slot. An abort is a single-cycle pulse. An aborted slot becomes inactive with empty sets, and a granted finish does the same.
- R13: Within a slot, start takes precedence over finish, and finish takes precedence over access. Each slot asserts at most one of grant, stall and abort in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lazy_mode | input | 1 | 1 selects checking at finish time; 0 selects checking on every access |
| begin_req | input | 2 | Per-slot start request |
| commit_req | input | 2 | Per-slot finish request |
| acc_req | input | 2 | Per-slot load/store request |
| acc_wr | input | 2 | Per-slot access kind: 1 store, 0 load |
| acc_idx | input | 2 x IDX_W | Per-slot granule index |
| grant | output | 2 | Per-slot request accepted this cycle |
| stall | output | 2 | Per-slot request refused; retry later |
| abort | output | 2 | Per-slot transaction aborted this cycle |

## Verification
Directed patterns drive each case in turn:

- **Shared load versus load against store.** A load of a granule the other slot has read, compared with a load of a granule it has written. This separates read-read sharing from a real conflict.
- **Younger-first versus older-first clash.** The same clash on one granule is raised once by the younger slot and once by the older slot. This separates the stall outcome from the abort outcome, and a second pair with slot 1 started first shows that age follows start order, not slot number.
- **Lazy finish, overlap and no overlap.** Lazy finishes are tried with and without write-set overlap, and with both slots finishing together.
- **Restart and finish racing an access.** A restart followed by a finish shows that the restart emptied the sets. A finish racing an access from the other slot shows that the access is held back.

A long run of random requests over a small pool of granules, with the mode switched from time to time, then mixes every ordering above.

// File: rtl/rwsc_pkg.sv
package rwsc_pkg;
   localparam int NTXN = 2;

   // A load clashes with a peer store; a store clashes with any peer touch.
   function automatic logic clash(input logic is_store, input logic peer_rd, input logic peer_wr);
      return peer_wr | (is_store & peer_rd);
   endfunction
endpackage

// File: rtl/rwsc_track.sv
module rwsc_track #(
   parameter int IDX_W = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clr,
   input  logic                  start,
   input  logic                  rec_en,
   input  logic                  rec_wr,
   input  logic [IDX_W-1:0]      rec_idx,
   output logic [(1<<IDX_W)-1:0] rset,
   output logic [(1<<IDX_W)-1:0] wset,
   output logic                  active
);
   localparam int NG = 1 << IDX_W;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rset   <= '0;
         wset   <= '0;
         active <= 1'b0;
      end else begin
         if (clr) begin
            rset <= '0;
            wset <= '0;
         end else if (rec_en) begin
            if (rec_wr) wset[rec_idx] <= 1'b1;
            else        rset[rec_idx] <= 1'b1;
         end
         if (start)    active <= 1'b1;
         else if (clr) active <= 1'b0;
      end
   end

   assert_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (rset == {NG{1'b0}} && wset == {NG{1'b0}}));

   assert_record_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_en && !clr) |=> ($past(rec_wr) ? wset[$past(rec_idx)] : rset[$past(rec_idx)]));
endmodule

// File: rtl/rwsc_probe.sv
module rwsc_probe
   import rwsc_pkg::*;
#(
   parameter int IDX_W = 4
) (
   input  logic                  acc_wr,
   input  logic [IDX_W-1:0]      acc_idx,
   input  logic [(1<<IDX_W)-1:0] own_w,
   input  logic [(1<<IDX_W)-1:0] peer_r,
   input  logic [(1<<IDX_W)-1:0] peer_w,
   input  logic                  peer_live,
   output logic                  acc_hit,
   output logic                  cmt_hit
);
   always_comb begin
      acc_hit = peer_live & clash(acc_wr, peer_r[acc_idx], peer_w[acc_idx]);
      cmt_hit = peer_live & (|(own_w & (peer_r | peer_w)));
   end
endmodule

// File: rtl/rwsc_detector.sv
module rwsc_detector
   import rwsc_pkg::*;
#(
   parameter int IDX_W = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       lazy_mode,
   input  logic [1:0]                 begin_req,
   input  logic [1:0]                 commit_req,
   input  logic [1:0]                 acc_req,
   input  logic [1:0]                 acc_wr,
   input  logic [1:0][IDX_W-1:0]      acc_idx,
   output logic [1:0]                 grant,
   output logic [1:0]                 stall,
   output logic [1:0]                 abort
);
   localparam int NG = 1 << IDX_W;

   if (IDX_W < 1 || IDX_W > 10) begin : g_bad_idx
      $error("rwsc_detector: IDX_W out of range");
   end

   logic [NG-1:0] rset [NTXN];
   logic [NG-1:0] wset [NTXN];
   logic [1:0] active, live, cmt_q, acc_q, is_old;
   logic [1:0] acc_hit, cmt_hit, cwin, acc_eval, kill_peer, hold, acc_ok;
   logic       older_q;

   for (genvar g = 0; g < NTXN; g++) begin : g_base
      localparam int P = 1 - g;
      assign live[g]   = active[g] & ~begin_req[g];
      assign cmt_q[g]  = live[g] & commit_req[g];
      assign acc_q[g]  = live[g] & ~commit_req[g] & acc_req[g];
      assign is_old[g] = (older_q == 1'(g));

      rwsc_probe #(.IDX_W(IDX_W)) u_probe (
         .acc_wr   (acc_wr[g]),
         .acc_idx  (acc_idx[g]),
         .own_w    (wset[g]),
         .peer_r   (rset[P]),
         .peer_w   (wset[P]),
         .peer_live(live[P]),
         .acc_hit  (acc_hit[g]),
         .cmt_hit  (cmt_hit[g])
      );
   end

   for (genvar g = 0; g < NTXN; g++) begin : g_arb
      localparam int P = 1 - g;
      assign cwin[g]      = cmt_q[g] & ~(cmt_q[P] & is_old[P]);
      assign acc_eval[g]  = acc_q[g] & ~cwin[P] & ~(~lazy_mode & acc_q[P] & is_old[P]);
      assign kill_peer[g] = (lazy_mode & cwin[g] & cmt_hit[g])
                          | (~lazy_mode & acc_eval[g] & acc_hit[g] & is_old[g]);
      assign hold[g]      = ~lazy_mode & acc_eval[g] & acc_hit[g] & is_old[P];
      assign abort[g]     = kill_peer[P];
      assign acc_ok[g]    = acc_eval[g] & ~hold[g] & ~abort[g];
      assign grant[g]     = begin_req[g] | (cwin[g] & ~abort[g]) | acc_ok[g];
      assign stall[g]     = (cmt_q[g] | acc_q[g]) & ~grant[g] & ~abort[g];

      rwsc_track #(.IDX_W(IDX_W)) u_track (
         .clk    (clk),
         .rst_n  (rst_n),
         .clr    (begin_req[g] | abort[g] | cwin[g]),
         .start  (begin_req[g]),
         .rec_en (acc_ok[g]),
         .rec_wr (acc_wr[g]),
         .rec_idx(acc_idx[g]),
         .rset   (rset[g]),
         .wset   (wset[g]),
         .active (active[g])
      );

      assert_excl_R13: assert property (@(posedge clk) disable iff (!rst_n)
         $onehot0({grant[g], stall[g], abort[g]}));
      assert_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
         abort[g] |=> !abort[g]);
      assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
         (!active[g] && !begin_req[g]) |-> !(grant[g] || stall[g] || abort[g]));
      assert_lazy_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (lazy_mode && acc_q[g] && !cwin[P]) |-> grant[g]);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                older_q <= 1'b0;
      else if (begin_req == 2'b11) older_q <= 1'b0;
      else if (begin_req[0])     older_q <= active[1];
      else if (begin_req[1])     older_q <= ~active[0];
   end

   assert_one_commit_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(cwin[0] && cwin[1]));
endmodule

// File: tb/rwsc_detector_tb.sv
module rwsc_detector_tb;
   localparam int PER = 10;
   localparam int IW  = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic lazy_mode = 1'b0;
   logic [1:0] begin_req = '0, commit_req = '0, acc_req = '0, acc_wr = '0;
   logic [1:0][IW-1:0] acc_idx = '0;
   logic [1:0] grant, stall, abort;

   int vectors = 0;
   int miscompares = 0;

   logic [15:0] mr [2];
   logic [15:0] mw [2];
   bit          ma [2];
   int          mo;

   always #(PER/2) clk = ~clk;

   rwsc_detector #(.IDX_W(IW)) u_dut (
      .clk(clk), .rst_n(rst_n), .lazy_mode(lazy_mode),
      .begin_req(begin_req), .commit_req(commit_req), .acc_req(acc_req),
      .acc_wr(acc_wr), .acc_idx(acc_idx),
      .grant(grant), .stall(stall), .abort(abort)
   );

   task automatic idle();
      begin_req = '0; commit_req = '0; acc_req = '0; acc_wr = '0; acc_idx = '0;
   endtask

   task automatic beg(input int i);
      begin_req[i] = 1'b1;
   endtask

   task automatic cmt(input int i);
      commit_req[i] = 1'b1;
   endtask

   task automatic acc(input int i, input bit w, input int x);
      acc_req[i] = 1'b1; acc_wr[i] = w; acc_idx[i] = IW'(x);
   endtask

   // One clock: build expected responses, compare, then advance the model.
   task automatic cyc(input string tag);
      int  k [2];
      bit  lv [2];
      bit  eg [2], es [2], ea [2], rc [2];
      int  cw, older_next;
      #1;
      for (int i = 0; i < 2; i++) begin
         eg[i] = 0; es[i] = 0; ea[i] = 0; rc[i] = 0;
         if (begin_req[i])      k[i] = 1;
         else if (!ma[i])       k[i] = 0;
         else if (commit_req[i]) k[i] = 2;
         else if (acc_req[i])   k[i] = 3;
         else                   k[i] = 0;
         lv[i] = ma[i] && (k[i] != 1);
         if (k[i] == 1) eg[i] = 1;
      end
      cw = -1;
      if (k[0] == 2 && k[1] == 2) cw = mo;
      else if (k[0] == 2)         cw = 0;
      else if (k[1] == 2)         cw = 1;
      if (cw >= 0) begin
         eg[cw] = 1;
         if (lazy_mode && lv[1-cw] && ((mw[cw] & (mr[1-cw] | mw[1-cw])) != 16'h0)) ea[1-cw] = 1;
         if (k[1-cw] == 2 && !ea[1-cw]) es[1-cw] = 1;
      end
      for (int n = 0; n < 2; n++) begin
         int  i, o;
         bit  hit;
         i = (n == 0) ? mo : 1 - mo;
         o = 1 - i;
         if (k[i] == 3 && !ea[i]) begin
            hit = lv[o] && (acc_wr[i] ? (mr[o][acc_idx[i]] | mw[o][acc_idx[i]]) : mw[o][acc_idx[i]]);
            if (cw == o) es[i] = 1;
            else if (!lazy_mode && n == 1 && k[o] == 3) es[i] = 1;
            else if (!lazy_mode && hit) begin
               if (o == mo) es[i] = 1;
               else begin eg[i] = 1; rc[i] = 1; ea[o] = 1; end
            end else begin eg[i] = 1; rc[i] = 1; end
         end
      end
      for (int i = 0; i < 2; i++) begin
         vectors++;
         if (grant[i] !== eg[i] || stall[i] !== es[i] || abort[i] !== ea[i]) begin
            miscompares++;
            $display("FAIL %s slot%0d: got g/s/a=%b%b%b expected %b%b%b at %0t",
                     tag, i, grant[i], stall[i], abort[i], eg[i], es[i], ea[i], $time);
         end
      end
      older_next = mo;
      if (begin_req == 2'b11)  older_next = 0;
      else if (begin_req[0])   older_next = ma[1] ? 1 : 0;
      else if (begin_req[1])   older_next = ma[0] ? 0 : 1;
      @(posedge clk);
      for (int i = 0; i < 2; i++) begin
         if (k[i] == 1) begin mr[i] = 0; mw[i] = 0; ma[i] = 1; end
         else if (ea[i] || cw == i) begin mr[i] = 0; mw[i] = 0; ma[i] = 0; end
         else if (rc[i]) begin
            if (acc_wr[i]) mw[i][acc_idx[i]] = 1'b1;
            else           mr[i][acc_idx[i]] = 1'b1;
         end
      end
      mo = older_next;
      @(negedge clk);
      idle();
   endtask

   initial begin
      #(PER * 200000);
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      for (int i = 0; i < 2; i++) begin mr[i] = 0; mw[i] = 0; ma[i] = 0; end
      mo = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state and requests from inactive slots
      cyc("R1 idle");
      acc(0, 1, 3); cmt(1); cyc("R1 inactive requests");
      // R2: simultaneous start, slot 0 older
      beg(0); beg(1); cyc("R2 start both");
      // R4 eager grants; R3 read-read sharing
      acc(0, 0, 3); cyc("R4 load");
      acc(1, 0, 3); cyc("R3 read-read");
      acc(1, 1, 5); cyc("R4 store");
      // R5 younger store hits older read-set
      acc(1, 1, 3); cyc("R5 younger stalls");
      // R6 older load hits younger write-set
      acc(0, 0, 5); cyc("R6 older aborts younger");
      cyc("R12 abort pulse ends");
      acc(1, 0, 5); cyc("R12 aborted slot inactive");
      // R7 simultaneous access
      beg(1); cyc("R2 restart slot1");
      acc(0, 1, 7); acc(1, 0, 9); cyc("R7 both access");
      // R11 eager finish, R12 access vs finish
      cmt(0); acc(1, 0, 9); cyc("R11 eager commit");
      cmt(1); cyc("R11 commit slot1");
      // R2 age by start order
      beg(1); cyc("R2 slot1 first");
      beg(0); cyc("R2 slot0 second");
      acc(0, 1, 2); cyc("R4 younger store");
      acc(1, 0, 2); cyc("R6 slot1 older aborts slot0");
      // R3 write-write conflict
      beg(0); cyc("R2 restart slot0");
      acc(1, 1, 11); cyc("R4 store");
      acc(0, 1, 11); cyc("R3 write-write");
      cmt(1); cyc("R11 commit");
      cmt(0); cyc("R11 commit");
      // Lazy mode
      lazy_mode = 1'b1;
      beg(0); beg(1); cyc("R2 lazy start");
      acc(0, 1, 4); cyc("R8 store");
      acc(1, 0, 4); cyc("R8 unchecked load");
      acc(1, 1, 4); cyc("R8 unchecked store");
      cmt(1); cyc("R9 commit aborts other");
      acc(0, 0, 1); cyc("R1 aborted inactive");
      beg(0); beg(1); cyc("R2 lazy start");
      acc(0, 1, 1); acc(1, 1, 2); cyc("R8 both access");
      cmt(0); cyc("R9 no overlap");
      cmt(1); cyc("R9 second commit");
      // R10 simultaneous finish
      beg(0); beg(1); cyc("R2 start");
      acc(0, 1, 6); acc(1, 0, 8); cyc("R8 access");
      cmt(0); cmt(1); cyc("R10 older wins, younger stalls");
      cmt(1); cyc("R10 younger granted next");
      beg(0); beg(1); cyc("R2 start");
      acc(0, 1, 6); acc(1, 0, 6); cyc("R8 access");
      cmt(0); cmt(1); cyc("R10 younger aborted");
      // R13 precedence: restart clears sets
      beg(0); beg(1); cyc("R2 start");
      acc(0, 1, 1); cyc("R8 store");
      beg(0); cmt(0); acc(0, 1, 9); cyc("R13 start wins");
      acc(1, 0, 1); cyc("R8 load");
      cmt(0); cyc("R13 restart emptied sets");
      cmt(1); acc(0, 0, 1); cyc("R12 access vs commit");
      // Mixed random traffic
      for (int c = 0; c < 4000; c++) begin
         if (c % 250 == 0) lazy_mode = $urandom % 2;
         for (int i = 0; i < 2; i++) begin
            int r;
            r = $urandom % 100;
            if (r < 4)       beg(i);
            else if (r < 12) cmt(i);
            else if (r < 65) acc(i, $urandom % 2, $urandom % 6);
            if ($urandom % 10 == 0) acc_req[i] = 1'b1;
         end
         cyc("mixed");
      end
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule